// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block arbitrates eight interrupt request lines on behalf of a small stack-based processor core. On every instruction cycle that is not an I/O cycle it copies the request lines into a pending register. Each level keeps its pending bit until its service routine returns, so a second request on a level that is still pending simply merges into the bit that is already set.

A second register records which levels are in service. The core is asked to take an interrupt only if the global enable flag is set and the highest pending level lies strictly above every in-service level. Lower or equal levels therefore wait, and a higher level can preempt a running routine. While the request is raised, the block presents the winning level and its service vector.

When the core acknowledges, the winning level becomes active. When the core signals a return from interrupt, the highest active level is retired: its pending bit and its active bit are both cleared.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all pending and active bits. `irq_o` is low in the cycle after reset.
- R2: In a cycle where `cyc_stb_i` is high and `io_cyc_i` is low, bit k of `req_i` sets the pending bit of level k at the next edge.
- R3: In a cycle where `cyc_stb_i` is low or `io_cyc_i` is high, `req_i` has no effect.
- R4: `irq_o` is high only when the highest pending level is strictly greater than every active level. Nesting is therefore possible only by higher levels.
- R5: When `gie_i` is low, `irq_o` is low, but requests are still latched. They are presented once `gie_i` returns high.
- R6: Level 7 has the highest priority and level 0 the lowest. While `irq_o` is high, `lvl_o` is the highest pending level.
- R7: `vec_o` equals `VEC_BASE + lvl_o * VEC_STEP` (64 + 8·level with the default parameters).
- R8: `ack_i` while `irq_o` is high sets the active bit of `lvl_o` at the next edge.
- R9: `rti_i` clears both the pending and the active bit of the highest active level. A request sampled in the same cycle is kept.
- R10: A request on a level whose pending bit is already set is absorbed: one acknowledge plus one return retires it entirely.
- R11: `ack_i` while `irq_o` is low has no effect.
- R12: `rti_i` while no level is active has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 8 | Request lines, bit k is level k |
| cyc_stb_i | input | 1 | Instruction-cycle strobe |
| io_cyc_i | input | 1 | Current cycle is an I/O instruction |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 1 | Interrupt acknowledge from the core |
| rti_i | input | 1 | Return-from-interrupt indication |
| irq_o | output | 1 | Interrupt request to the core |
| lvl_o | output | 3 | Selected level |
| vec_o | output | VEC_W (12) | Service vector of the selected level |

## Verification
The bench targets several corner cases:
- A request raised during an I/O cycle. A design that samples anyway would interrupt early.
- A lower or equal level arriving while a higher one is in service. A design that compares against pending rather than active levels would either deadlock nesting or preempt wrongly.
- A return that coincides with a new request on the retiring level. Clearing after sampling would silently drop that request.
- A repeated request on an already pending level, an acknowledge without a request, and a return with nothing active. Each of these must leave the state untouched, or spurious interrupts or lost levels follow.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;
    localparam int unsigned LVL_N = 8;
    localparam int unsigned LVL_W = $clog2(LVL_N);

    typedef struct packed {
        logic [LVL_N-1:0] pend;
        logic [LVL_N-1:0] act;
    } irq_state_t;
endpackage

// File: rtl/nest_irq_prio.sv
module nest_irq_prio #(
    parameter  int unsigned W  = 8,
    localparam int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]  bits_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    // highest set bit wins: scanning upward lets later hits overwrite
    always_comb begin
        any_o = |bits_i;
        idx_o = '0;
        for (int i = 0; i < int'(W); i++) begin
            if (bits_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/nest_irq_vtab.sv
module nest_irq_vtab #(
    parameter  int unsigned N    = 8,
    parameter  int unsigned VW   = 12,
    parameter  int unsigned BASE = 64,
    parameter  int unsigned STEP = 8,
    localparam int unsigned IW   = $clog2(N)
) (
    input  logic [IW-1:0] lvl_i,
    output logic [VW-1:0] vec_o
);
    logic [VW-1:0] tab [N];

    for (genvar g = 0; g < int'(N); g++) begin : g_entry
        assign tab[g] = VW'(BASE + g * STEP);
    end

    assign vec_o = tab[lvl_i];
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nest_irq_pkg::*;
#(
    parameter int unsigned VEC_W    = 12,
    parameter int unsigned VEC_BASE = 64,
    parameter int unsigned VEC_STEP = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_N-1:0] req_i,
    input  logic             cyc_stb_i,
    input  logic             io_cyc_i,
    input  logic             gie_i,
    input  logic             ack_i,
    input  logic             rti_i,
    output logic             irq_o,
    output logic [LVL_W-1:0] lvl_o,
    output logic [VEC_W-1:0] vec_o
);
    irq_state_t       st_d, st_q;
    logic             hp_any, ha_any, eligible, irq_w;
    logic [LVL_W-1:0] hp_idx, ha_idx;
    logic [LVL_N-1:0] smp_mask, clr_mask, set_mask;

    nest_irq_prio #(.W(LVL_N)) u_pend_prio (
        .bits_i (st_q.pend),
        .any_o  (hp_any),
        .idx_o  (hp_idx)
    );

    nest_irq_prio #(.W(LVL_N)) u_act_prio (
        .bits_i (st_q.act),
        .any_o  (ha_any),
        .idx_o  (ha_idx)
    );

    nest_irq_vtab #(
        .N    (LVL_N),
        .VW   (VEC_W),
        .BASE (VEC_BASE),
        .STEP (VEC_STEP)
    ) u_vtab (
        .lvl_i (hp_idx),
        .vec_o (vec_o)
    );

    always_comb begin
        eligible = hp_any && (!ha_any || (hp_idx > ha_idx));
        irq_w    = gie_i && eligible;
    end

    assign irq_o = irq_w;
    assign lvl_o = hp_idx;

    always_comb begin
        smp_mask  = (cyc_stb_i && !io_cyc_i) ? req_i : '0;
        clr_mask  = (rti_i && ha_any) ? (LVL_N'(1) << ha_idx) : '0;
        set_mask  = (ack_i && irq_w)  ? (LVL_N'(1) << hp_idx) : '0;
        st_d      = st_q;
        // retire first, then merge fresh samples so a same-cycle request survives
        st_d.pend = (st_q.pend & ~clr_mask) | smp_mask;
        st_d.act  = (st_q.act  & ~clr_mask) | set_mask;
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R1: reset leaves no request behind
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (st_q == '0) && !irq_o);

    // R2: a sampled line lands in the pending register
    p_sample_r2: assert property (@(posedge clk) disable iff (rst)
        (cyc_stb_i && !io_cyc_i) |=> ((st_q.pend & $past(req_i)) == $past(req_i)));

    // R3: without a sampling cycle, no pending bit can appear
    p_no_sample_r3: assert property (@(posedge clk) disable iff (rst)
        !(cyc_stb_i && !io_cyc_i) |=> ((st_q.pend & ~$past(st_q.pend)) == '0));

    // R4: a request must outrank every level in service
    p_outrank_r4: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> st_q.pend[lvl_o] && ((st_q.act >> lvl_o) == '0));

    // R5: a cleared enable blocks the request
    p_gie_block_r5: assert property (@(posedge clk) disable iff (rst)
        !gie_i |-> !irq_o);

    // R6: the presented level is the top pending one
    p_highest_r6: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ((st_q.pend >> lvl_o) == LVL_N'(1)));

    // R8: an accepted acknowledge marks the level active
    p_ack_sets_r8: assert property (@(posedge clk) disable iff (rst)
        (ack_i && irq_o) |=> st_q.act[$past(lvl_o)]);

    // R9: a return retires the top active level
    p_rti_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (rti_i && (st_q.act != '0)) |=> !st_q.act[$past(ha_idx)]);

    // R11: a stray acknowledge leaves the in-service set alone
    p_stray_ack_r11: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !irq_o && !rti_i) |=> $stable(st_q.act));

    // R12: a return with nothing active changes nothing but sampling
    p_idle_rti_r12: assert property (@(posedge clk) disable iff (rst)
        (rti_i && (st_q.act == '0) && !ack_i) |=> (st_q.act == '0));
endmodule

// File: tb/nest_irq_ctrl_tb.sv
`timescale 1ns/1ps
module nest_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] req;
    logic       stb, io, gie, ack, rti;
    logic       irq;
    logic [2:0] lvl;
    logic [11:0] vec;

    int n_chk = 0;
    int n_bad = 0;

    // behavioural reference state
    bit m_pend [8];
    bit m_act  [8];

    always #4 clk = ~clk;

    nest_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .req_i(req), .cyc_stb_i(stb), .io_cyc_i(io),
        .gie_i(gie), .ack_i(ack), .rti_i(rti),
        .irq_o(irq), .lvl_o(lvl), .vec_o(vec)
    );

    function automatic int top_pend();
        for (int k = 7; k >= 0; k--) if (m_pend[k]) return k;
        return -1;
    endfunction

    function automatic int top_act();
        for (int k = 7; k >= 0; k--) if (m_act[k]) return k;
        return -1;
    endfunction

    function automatic bit exp_irq();
        return gie && (top_pend() >= 0) && (top_pend() > top_act());
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 8; k++) begin m_pend[k] = 0; m_act[k] = 0; end
        end else begin
            int hp, ha;
            bit fire;
            hp = top_pend(); ha = top_act(); fire = exp_irq();
            if (rti && ha >= 0) begin m_pend[ha] = 0; m_act[ha] = 0; end
            if (ack && fire) m_act[hp] = 1;
            if (stb && !io)
                for (int k = 0; k < 8; k++) if (req[k]) m_pend[k] = 1;
        end
    end

    task automatic chk(input string tag, input int act_v, input int exp_v);
        n_chk++;
        if (act_v != exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    // compare every output against the model (R4 R5 R6 R7)
    task automatic cmp_model();
        chk("R4 irq vs model", irq, exp_irq());
        if (exp_irq()) begin
            chk("R6 level vs model", lvl, top_pend());
            chk("R7 vector vs model", vec, 64 + top_pend() * 8);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cmp_model();
    endtask

    task automatic idle();
        req = 0; stb = 1; io = 0; ack = 0; rti = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 0);
        $finish;
    end

    initial begin
        rst = 1; gie = 1; idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk("R1 irq after reset", irq, 0);

        // R3: request in an I/O cycle, then with no strobe
        req = 8'h08; io = 1; tick();
        io = 0; stb = 0; tick();
        idle(); tick();
        chk("R3 no sample in io/no-strobe cycle", irq, 0);

        // R2 R6 R7: sampled request appears
        req = 8'h08; tick(); idle();
        chk("R2 sampled level raises irq", irq, 1);
        chk("R6 level 3 selected", lvl, 3);
        chk("R7 vector of level 3", vec, 64 + 3 * 8);

        // R5: enable low blocks, keeps pending
        gie = 0; tick();
        chk("R5 gie low blocks", irq, 0);
        req = 8'h01; tick(); idle();
        gie = 1; tick();
        chk("R5 pending presented after gie", irq, 1);
        chk("R6 highest of 3 and 0", lvl, 3);

        // R8: acknowledge level 3
        ack = 1; tick(); ack = 0;
        chk("R8 ack drops request for same level", irq, 0);

        // R4: lower level 2 waits, higher level 5 preempts
        req = 8'h04; tick(); idle(); tick();
        chk("R4 lower level waits", irq, 0);
        req = 8'h20; tick(); idle();
        chk("R4 higher level nests", irq, 1);
        chk("R6 nested level 5", lvl, 5);
        chk("R7 vector of level 5", vec, 64 + 5 * 8);
        ack = 1; tick(); ack = 0;

        // R10: repeated request on pending level 2 merges
        req = 8'h04; tick(); idle();

        // R9: return retires level 5, level 3 still blocks 2
        rti = 1; tick(); rti = 0;
        chk("R9 return from 5, level 3 still active", irq, 0);
        rti = 1; tick(); rti = 0;
        chk("R9 return from 3 exposes level 2", irq, 1);
        chk("R9 exposed level", lvl, 2);
        ack = 1; tick(); ack = 0;
        rti = 1; tick(); rti = 0;
        chk("R10 merged level 2 fully retired", irq, 1);
        chk("R10 only level 0 left", lvl, 0);

        // R11: stray ack with gie low keeps level 0 idle
        gie = 0; ack = 1; tick(); ack = 0; gie = 1; tick();
        chk("R11 stray ack ignored", irq, 1);
        chk("R11 level still 0", lvl, 0);

        // R12: return with nothing active keeps pending level 0
        rti = 1; tick(); rti = 0;
        chk("R12 idle return ignored", irq, 1);

        // R9: return on level 0 with a same-cycle request on level 0 keeps it
        ack = 1; tick(); ack = 0;
        chk("R8 level 0 in service", irq, 0);
        rti = 1; req = 8'h01; tick(); idle();
        chk("R9 same-cycle request survives return", irq, 1);
        ack = 1; tick(); ack = 0; rti = 1; tick(); rti = 0;
        chk("R9 all retired", irq, 0);

        // randomized phase against the model
        for (int c = 0; c < 4000; c++) begin
            req = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
            stb = ($urandom_range(0, 3) != 0);
            io  = ($urandom_range(0, 4) == 0);
            gie = ($urandom_range(0, 9) != 0);
            ack = irq ? ($urandom_range(0, 1) == 1) : ($urandom_range(0, 19) == 0);
            rti = ($urandom_range(0, 7) == 0);
            tick();
        end

        // R1: reset mid-stream
        rst = 1; idle(); tick(); rst = 0; tick();
        chk("R1 irq after second reset", irq, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule